// File: doc/BRIEF.md
# Quarter-Phase Event Timestamper

This block records the arrival time of rising edges on an asynchronous pulse line with a resolution of one quarter of its system clock period. Four capture registers watch the line. Each is clocked on a different quarter phase, taken from a true clock and a quadrature clock using both edge polarities. The four samples are then walked into the true-clock rising-edge domain, moving by no more than a quarter period per register stage. A decoder finds the first quarter in which the line went from low to high. That two-bit quarter index is placed below a free-running coarse count of clock periods to form the timestamp.

A sync strobe restarts the coarse count at zero, so every later timestamp is measured from the sync. Timestamps go into an on-chip event queue. A slower host drains the queue through a show-ahead read port with a pop strobe. When the queue is full, new events are discarded and a sticky overflow flag is raised. Pulses that are closer together than one clock period are outside the intended operating range.

Top module: `evt_stamp_top`

## Requirements
- R1: While reset is asserted and right after it is released, `rd_valid_o` and `ovf_o` are both low.
- R2: Bits [1:0] of a timestamp give the quarter of the period in which the rising edge arrived. If `clk_0` rises at time E and P is the period, an edge arriving in (E+(q-1)P/4, E+qP/4] gets index q, for q = 0..3.
- R3: Bits [31:2] give the window number w of that edge. Window 0 is the period that begins at the `clk_0` rising edge that samples `sync_i` high, and each later `clk_0` rising edge starts the next window. The count wraps silently.
- R4: A line held high for many periods produces exactly one event. Its falling edge produces none.
- R5: A new sync pulse restarts the window numbering at zero for all later events.
- R6: Events leave the queue oldest first. While `rd_valid_o` is high, `rd_data_o` shows the oldest entry, and a `rd_i` high at a `clk_0` rising edge removes it.
- R7: When the queue holds DEPTH entries, further events are discarded, the stored entries stay intact, and `ovf_o` goes high and stays high until reset.
- R8: `rd_i` has no effect while the queue is empty.
- R9: For an edge in window w that reaches an empty queue, `rd_valid_o` is still low after the rising edge that begins window w+1 and is high after the rising edge that begins window w+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_0 | input | 1 | System clock, 0 degree phase; the common domain |
| clk_90 | input | 1 | Same clock delayed by a quarter period |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Restarts the coarse count at zero (clk_0 domain) |
| pulse_i | input | 1 | Asynchronous event line; rising edges are stamped |
| rd_i | input | 1 | Pops the oldest queue entry |
| rd_data_o | output | 32 | Oldest stored timestamp: {window, quarter} |
| rd_valid_o | output | 1 | Queue is not empty |
| ovf_o | output | 1 | Sticky flag: an event was discarded |

## Verification
An edge in window w reaches the aligned sample register at the rising edge that begins window w+1. It is written into the queue one edge later. The bench therefore probes `rd_valid_o` 1 ns after each of those two edges. Stimulus edges are placed 1.25 ns inside a chosen quarter, so no capture register sees the line change on its own clock edge. Queue contents are compared only after the last pulse of a group has had several periods to drain. Pops are driven 1 ns after a rising edge and take effect at the next one.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;

    // Number of clock phases sampling the event line and bits to encode one.
    localparam int PHASES = 4;
    localparam int PW     = $clog2(PHASES);

    // Index of the lowest set bit of a rise vector (0 when empty).
    function automatic logic [PW-1:0] lowest_rise(input logic [PHASES-1:0] r);
        logic [PW-1:0] idx;
        idx = '0;
        for (int k = PHASES - 1; k >= 0; k--) begin
            if (r[k]) idx = PW'(k);
        end
        return idx;
    endfunction

endpackage

// File: rtl/phase_sampler.sv
module phase_sampler (
    input  logic       clk_0,
    input  logic       clk_90,
    input  logic       rst_n,
    input  logic       pulse_i,
    output logic [3:0] aligned_o
);
    // Capture stage: one register per quarter phase.
    logic cap0_q, cap1_q, cap2_q, cap3_q;
    // Retiming stages, each a quarter period after the one before.
    logic c0_90_q, c0_180_q, c0_270_q;
    logic c1_180_q, c1_270_q;
    logic c2_270_q;
    logic [3:0] aligned_q;

    always_ff @(posedge clk_0 or negedge rst_n) begin
        if (!rst_n) begin
            cap0_q    <= 1'b0;
            aligned_q <= '0;
        end else begin
            cap0_q    <= pulse_i;
            aligned_q <= {cap3_q, c2_270_q, c1_270_q, c0_270_q};
        end
    end

    always_ff @(posedge clk_90 or negedge rst_n) begin
        if (!rst_n) begin
            cap1_q  <= 1'b0;
            c0_90_q <= 1'b0;
        end else begin
            cap1_q  <= pulse_i;
            c0_90_q <= cap0_q;
        end
    end

    always_ff @(negedge clk_0 or negedge rst_n) begin
        if (!rst_n) begin
            cap2_q   <= 1'b0;
            c0_180_q <= 1'b0;
            c1_180_q <= 1'b0;
        end else begin
            cap2_q   <= pulse_i;
            c0_180_q <= c0_90_q;
            c1_180_q <= cap1_q;
        end
    end

    always_ff @(negedge clk_90 or negedge rst_n) begin
        if (!rst_n) begin
            cap3_q   <= 1'b0;
            c0_270_q <= 1'b0;
            c1_270_q <= 1'b0;
            c2_270_q <= 1'b0;
        end else begin
            cap3_q   <= pulse_i;
            c0_270_q <= c0_180_q;
            c1_270_q <= c1_180_q;
            c2_270_q <= cap2_q;
        end
    end

    assign aligned_o = aligned_q;

endmodule

// File: rtl/stamp_gen.sv
module stamp_gen
    import evt_stamp_pkg::*;
#(
    parameter int CW = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [PHASES-1:0] aligned_i,
    output logic             ev_valid_o,
    output logic [CW+PW-1:0] ev_stamp_o
);
    typedef struct packed {
        logic [CW-1:0] coarse;
        logic          last;
    } gen_t;

    gen_t st_d, st_q;
    logic [PHASES:0]   chain;
    logic [PHASES-1:0] rise;

    always_comb begin
        chain = {aligned_i, st_q.last};
        for (int k = 0; k < PHASES; k++) begin
            rise[k] = chain[k+1] & ~chain[k];
        end
        ev_valid_o = |rise;
        // Aligned samples belong to the window before the current count.
        ev_stamp_o = {st_q.coarse - CW'(1), lowest_rise(rise)};

        st_d        = st_q;
        st_d.last   = aligned_i[PHASES-1];
        st_d.coarse = sync_i ? '0 : st_q.coarse + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (st_q.coarse == '0)); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> (st_q.coarse == $past(st_q.coarse) + CW'(1))); // R3

endmodule

// File: rtl/stamp_fifo.sv
module stamp_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_valid_o,
    output logic          ovf_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wr_ptr;
        logic [AW:0] rd_ptr;
        logic        ovf;
    } fifo_t;

    fifo_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   count;
    logic          full, empty, do_wr, do_rd;

    always_comb begin
        count = st_q.wr_ptr - st_q.rd_ptr;
        full  = (count == (AW+1)'(DEPTH));
        empty = (count == '0);
        do_wr = wr_i && !full;
        do_rd = rd_i && !empty;

        st_d = st_q;
        if (do_wr)        st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        if (do_rd)        st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        if (wr_i && full) st_d.ovf    = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[st_q.wr_ptr[AW-1:0]] <= wr_data_i;
    end

    assign rd_data_o  = mem[st_q.rd_ptr[AW-1:0]];
    assign rd_valid_o = !empty;
    assign ovf_o      = st_q.ovf;

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_i) |=> $stable(st_q.wr_ptr)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf); // R7
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_i) |=> $stable(st_q.rd_ptr)); // R8

endmodule

// File: rtl/evt_stamp_top.sv
module evt_stamp_top
    import evt_stamp_pkg::*;
#(
    parameter int CW    = 30,
    parameter int DEPTH = 512
) (
    input  logic             clk_0,
    input  logic             clk_90,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             pulse_i,
    input  logic             rd_i,
    output logic [CW+PW-1:0] rd_data_o,
    output logic             rd_valid_o,
    output logic             ovf_o
);
    localparam int TW = CW + PW;

    logic [PHASES-1:0] aligned;
    logic              ev_valid;
    logic [TW-1:0]     ev_stamp;

    phase_sampler u_sampler (
        .clk_0     (clk_0),
        .clk_90    (clk_90),
        .rst_n     (rst_n),
        .pulse_i   (pulse_i),
        .aligned_o (aligned)
    );

    stamp_gen #(.CW(CW)) u_gen (
        .clk        (clk_0),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .aligned_i  (aligned),
        .ev_valid_o (ev_valid),
        .ev_stamp_o (ev_stamp)
    );

    stamp_fifo #(.DW(TW), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk_0),
        .rst_n      (rst_n),
        .wr_i       (ev_valid),
        .wr_data_i  (ev_stamp),
        .rd_i       (rd_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .ovf_o      (ovf_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_0) disable iff (!rst_n)
        $rose(rst_n) |-> (!ovf_o)); // R1

endmodule

// File: tb/tb_evt_stamp_top.sv
`timescale 1ns/1ps
module tb_evt_stamp_top;
    localparam int DEPTH = 8;

    logic clk_0 = 1'b0, clk_90 = 1'b0, rst_n = 1'b0;
    logic sync_i = 1'b0, pulse_i = 1'b0, rd_i = 1'b0;
    logic [31:0] rd_data_o;
    logic rd_valid_o, ovf_o;

    int checks = 0, errors = 0, win = 0;
    bit done = 0, exp_ovf = 0;
    logic [31:0] model_q[$];

    evt_stamp_top #(.CW(30), .DEPTH(DEPTH)) dut (
        .clk_0(clk_0), .clk_90(clk_90), .rst_n(rst_n), .sync_i(sync_i),
        .pulse_i(pulse_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
        .rd_valid_o(rd_valid_o), .ovf_o(ovf_o)
    );

    initial forever #5 clk_0 = ~clk_0;
    initial begin
        #2.5;
        forever #5 clk_90 = ~clk_90;
    end

    // Window number as defined by R3.
    always @(posedge clk_0) begin
        if (sync_i) win <= 0;
        else        win <= win + 1;
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_sync();
        @(posedge clk_0); #1 sync_i = 1'b1;
        @(posedge clk_0); #1 sync_i = 1'b0;
    endtask

    task automatic note_event(input int w, input int ph);
        logic [31:0] e;
        e = {w[29:0], ph[1:0]};
        if (model_q.size() < DEPTH) model_q.push_back(e);
        else exp_ovf = 1;
    endtask

    // Raise the line 1.25 ns inside quarter ph of a window, hold for hold_ns.
    task automatic fire(input int ph, input real hold_ns);
        int w;
        @(posedge clk_0); #0.5 w = win;
        if (ph == 0) begin
            #8.25;
            w = w + 1;
        end else begin
            #(0.75 + 2.5 * (ph - 1));
        end
        pulse_i = 1'b1;
        note_event(w, ph);
        #(hold_ns) pulse_i = 1'b0;
        #25;
    endtask

    task automatic pop_check(input string tag);
        logic [31:0] e;
        e = model_q.pop_front();
        check({31'd0, rd_valid_o}, 32'd1, tag);
        check(rd_data_o, e, tag);
        @(posedge clk_0); #1 rd_i = 1'b1;
        @(posedge clk_0); #1 rd_i = 1'b0;
    endtask

    task automatic drain(input string tag);
        while (model_q.size() > 0) pop_check(tag);
        check({31'd0, rd_valid_o}, 32'd0, tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w;
        // R1: reset state
        #13;
        check({31'd0, rd_valid_o}, 32'd0, "R1 valid in reset");
        check({31'd0, ovf_o}, 32'd0, "R1 ovf in reset");
        #9 rst_n = 1'b1;
        #20;
        check({31'd0, rd_valid_o}, 32'd0, "R1 valid after reset");
        check({31'd0, ovf_o}, 32'd0, "R1 ovf after reset");

        do_sync();

        // R8: pop while empty has no effect
        @(posedge clk_0); #1 rd_i = 1'b1;
        @(posedge clk_0); #1 rd_i = 1'b0;
        #10;
        check({31'd0, rd_valid_o}, 32'd0, "R8 empty pop");

        // R9: latency of one edge in quarter 2
        @(posedge clk_0); #0.5 w = win;
        #3.25 pulse_i = 1'b1;
        note_event(w, 2);
        #6 pulse_i = 1'b0;
        @(posedge clk_0); #1;
        check({31'd0, rd_valid_o}, 32'd0, "R9 not yet at w+1");
        @(posedge clk_0); #1;
        check({31'd0, rd_valid_o}, 32'd1, "R9 ready at w+2");
        drain("R8 R6 after empty pop");

        // R2 R3 R6: sweep every quarter, two rounds
        for (int r = 0; r < 2; r++) begin
            for (int ph = 0; ph < 4; ph++) fire(ph, 6.0);
        end
        drain("R2 R3 R6 sweep");

        // R4: long high level gives one event
        fire(3, 60.0);
        #30;
        drain("R4 held high");

        // R5: new sync restarts numbering
        do_sync();
        fire(1, 6.0);
        fire(0, 6.0);
        drain("R5 resync");

        // R7: overflow drops new events, keeps stored ones
        check({31'd0, ovf_o}, 32'd0, "R7 ovf before full");
        for (int n = 0; n < DEPTH + 2; n++) fire(n % 4, 6.0);
        check({31'd0, ovf_o}, {31'd0, exp_ovf}, "R7 ovf set");
        drain("R7 kept entries");
        check({31'd0, ovf_o}, 32'd1, "R7 ovf sticky");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule